// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Engine

This block is a single DMA channel that reads its work orders from memory. Software writes the address of a descriptor block, enables the channel through the status register and rings a doorbell. The channel then reads an eight-word descriptor and copies a counted number of transfer units from a source address to a target address. It may then jump to another descriptor whose location is an offset from the base. A chain ends at a descriptor whose link flag is clear. At that point the channel records completion and, if the descriptor asks for it, raises an interrupt.

All memory traffic goes through one word-wide master port. The port carries one beat per valid/ready handshake, and a read returns one response word. Units of one byte and two bytes move through a single word beat with byte strobes, so the bytes around them are not touched. Units of four bytes or more are split into whole-word beats. A source or target address that is not aligned to the selected unit halts the channel and raises an address error. A chain whose last link offset points back to the base runs forever and never interrupts.

Register port select values: 0 writes the descriptor base address. 1 writes the status/control word. 2 writes the doorbell, where bit 0 starts a fetch.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset, status_o and count_o read 0, irq_o is low and no memory request is raised.
- R2: A doorbell write with bit 0 set starts a descriptor fetch at the base address only when status bit 0 (enable) is set. Otherwise the doorbell is ignored and no memory request follows. Bit 30 of the status word is kept as written. The fetch reads eight words in this order: command, source, target, count, stride difference, request type and two reserved words.
- R3: Command bits 10:8 select the unit: 0 means 4 bytes, 1 means 1, 2 means 2, 3 means 16, 4 means 32, 5 means 64 and 6 or 7 mean 128 bytes. Count-word bits 23:0 give the number of units to copy. Units of 4 bytes or more move as whole words from source to target.
- R4: A 1-byte or 2-byte unit is read from the source lane given by the low address bits. It is written to the target lane with only that lane's byte strobes set, and other bytes of the target word stay unchanged.
- R5: Command bit 23 makes the source address advance and bit 22 makes the target address advance. The step is the unit size for sub-word units and 4 bytes otherwise. With the bit clear, that address stays fixed.
- R6: When command bit 0 (link) is set, the next descriptor is fetched from the base plus count-word bits 31:24 times 16.
- R7: When a descriptor with link clear finishes, status bit 3 (terminated) is set. irq_o rises only if command bit 1 is set in that descriptor.
- R8: A chain whose final link offset is 0 loops back to the first descriptor and never sets bit 3 or irq_o. Writing status 0 stops the channel, clears bits 2, 3 and 4 and drops irq_o.
- R9: A source or target address that is not a multiple of the unit size sets status bit 4 (address error) and bit 2 (halt), and raises irq_o. No write for that descriptor reaches memory.
- R10: A descriptor with a count of 0 finishes without a data access, and its link bit is still followed.
- R11: count_o shows the units left in the current descriptor. It falls by one as each unit's last write is accepted, and reads 0 when the descriptor is done.
- R12: A memory request keeps its valid, address and direction stable until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 base, 1 status, 2 doorbell |
| reg_wdata_i | input | 32 | Register write data |
| status_o | output | 32 | Status: bit0 enable, bit2 halt, bit3 terminated, bit4 address error, bit30 8-word format |
| count_o | output | 24 | Units left in the current descriptor |
| irq_o | output | 1 | Interrupt, level, cleared by a status write |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory request accepted |
| mem_req_we_o | output | 1 | 1 for write, 0 for read |
| mem_req_addr_o | output | 32 | Word-aligned byte address |
| mem_req_wdata_o | output | 32 | Write data |
| mem_req_be_o | output | 4 | Write byte strobes |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 32 | Read data |

## Verification
The memory model accepts requests on random cycles and returns read data one cycle after acceptance, so no result arrives after a fixed number of cycles. Terminated and address-error status appear one cycle after the accepted final write or the alignment check. count_o falls in the cycle after each unit's last write is accepted. For these reasons the bench polls status_o at the falling edge with a bounded wait, and compares memory, irq_o and count_o only once the terminating bit is visible. Checks that something did not happen count accepted requests across a fixed quiet window. For the looping chain, the bench stops the channel before it compares memory.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FREQ, S_FRSP, S_CHECK, S_RREQ, S_RRSP, S_WREQ, S_ENDD
  } dma_state_e;

  localparam int unsigned ST_EN      = 0;
  localparam int unsigned ST_HALT    = 2;
  localparam int unsigned ST_TERM    = 3;
  localparam int unsigned ST_ADDRERR = 4;
  localparam int unsigned ST_WIDE    = 30;

  localparam int unsigned CMD_LINK = 0;
  localparam int unsigned CMD_TIE  = 1;
  localparam int unsigned CMD_DINC = 22;
  localparam int unsigned CMD_SINC = 23;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_BELL = 2'd2;
endpackage

// File: rtl/dma_unit_decode.sv
module dma_unit_decode #(
  parameter int unsigned AW = 32
) (
  input  logic [2:0]    tsz_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  output logic [2:0]    step_o,
  output logic [5:0]    beats_o,
  output logic          misalign_o
);
  logic [7:0] unit_b;

  always_comb begin
    case (tsz_i)
      3'd0:    unit_b = 8'd4;
      3'd1:    unit_b = 8'd1;
      3'd2:    unit_b = 8'd2;
      3'd3:    unit_b = 8'd16;
      3'd4:    unit_b = 8'd32;
      3'd5:    unit_b = 8'd64;
      default: unit_b = 8'd128;
    endcase
  end

  assign step_o     = (unit_b < 8'd4) ? unit_b[2:0] : 3'd4;
  assign beats_o    = (unit_b < 8'd4) ? 6'd1 : unit_b[7:2];
  assign misalign_o = |((src_i[6:0] | dst_i[6:0]) & (unit_b[6:0] - 7'd1));
endmodule

// File: rtl/dma_lane_steer.sv
module dma_lane_steer (
  input  logic [2:0]  step_i,
  input  logic [1:0]  src_lane_i,
  input  logic [1:0]  dst_lane_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] wdata_o,
  output logic [3:0]  be_o
);
  logic [15:0] half;
  logic [7:0]  byte_v;

  assign half   = src_lane_i[1] ? rdata_i[31:16] : rdata_i[15:0];
  assign byte_v = rdata_i[8*src_lane_i +: 8];

  always_comb begin
    case (step_i)
      3'd1: begin
        wdata_o = {4{byte_v}};
        be_o    = 4'b0001 << dst_lane_i;
      end
      3'd2: begin
        wdata_o = {2{half}};
        be_o    = dst_lane_i[1] ? 4'b1100 : 4'b0011;
      end
      default: begin
        wdata_o = rdata_i;
        be_o    = 4'b1111;
      end
    endcase
  end
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int unsigned AW         = 32,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned OFF_SH     = 4,
  parameter int unsigned DESC_WORDS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       status_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              irq_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic              mem_req_we_o,
  output logic [AW-1:0]     mem_req_addr_o,
  output logic [31:0]       mem_req_wdata_o,
  output logic [3:0]        mem_req_be_o,
  input  logic              mem_rsp_valid_i,
  input  logic [31:0]       mem_rsp_rdata_i
);
  localparam int unsigned FIDX_W = $clog2(DESC_WORDS);
  localparam int unsigned PAD_W  = AW - OFF_W - OFF_SH;

  dma_state_e        state_q;
  logic [AW-1:0]     base_reg_q, base_q, cur_q, src_q, dst_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [31:0]       cmd_q, cntw_q, rbuf_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [5:0]        beat_q;
  logic              st_en_q, st_wide_q, st_halt_q, st_term_q, st_err_q, irq_q;

  logic [2:0]  step;
  logic [5:0]  beats;
  logic        misalign;
  logic [31:0] wdata;
  logic [3:0]  be;
  logic        stat_wr, abort_w, bell_w, req_fire, cnt_load;
  logic [AW-1:0] next_desc;

  dma_unit_decode #(.AW(AW)) i_decode (
    .tsz_i(cmd_q[10:8]), .src_i(src_q), .dst_i(dst_q),
    .step_o(step), .beats_o(beats), .misalign_o(misalign)
  );

  dma_lane_steer i_steer (
    .step_i(step), .src_lane_i(src_q[1:0]), .dst_lane_i(dst_q[1:0]),
    .rdata_i(rbuf_q), .wdata_o(wdata), .be_o(be)
  );

  assign stat_wr   = reg_we_i && (reg_sel_i == SEL_STAT);
  assign abort_w   = stat_wr && !reg_wdata_i[ST_EN];
  assign bell_w    = reg_we_i && (reg_sel_i == SEL_BELL) && reg_wdata_i[0];
  assign req_fire  = mem_req_valid_o && mem_req_ready_i;
  assign cnt_load  = (state_q == S_FRSP) && mem_rsp_valid_i && (fidx_q == FIDX_W'(3));
  assign next_desc = base_q + {{PAD_W{1'b0}}, cntw_q[31 -: OFF_W], {OFF_SH{1'b0}}};

  assign mem_req_valid_o = (state_q == S_FREQ) || (state_q == S_RREQ) || (state_q == S_WREQ);
  assign mem_req_we_o    = (state_q == S_WREQ);
  assign mem_req_wdata_o = wdata;
  assign mem_req_be_o    = (state_q == S_WREQ) ? be : 4'b0000;

  always_comb begin
    case (state_q)
      S_FREQ:  mem_req_addr_o = cur_q + {{(AW-FIDX_W-2){1'b0}}, fidx_q, 2'b00};
      S_RREQ:  mem_req_addr_o = {src_q[AW-1:2], 2'b00};
      default: mem_req_addr_o = {dst_q[AW-1:2], 2'b00};
    endcase
  end

  assign status_o = {1'b0, st_wide_q, 25'd0, st_err_q, st_term_q, st_halt_q, 1'b0, st_en_q};
  assign count_o  = cnt_q;
  assign irq_o    = irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      base_reg_q <= '0;
      base_q     <= '0;
      cur_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      fidx_q     <= '0;
      cmd_q      <= '0;
      cntw_q     <= '0;
      rbuf_q     <= '0;
      cnt_q      <= '0;
      beat_q     <= '0;
      st_en_q    <= 1'b0;
      st_wide_q  <= 1'b0;
      st_halt_q  <= 1'b0;
      st_term_q  <= 1'b0;
      st_err_q   <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (reg_we_i && reg_sel_i == SEL_BASE) base_reg_q <= reg_wdata_i[AW-1:0];
      if (stat_wr) begin
        st_en_q   <= reg_wdata_i[ST_EN];
        st_wide_q <= reg_wdata_i[ST_WIDE];
        st_halt_q <= 1'b0;
        st_term_q <= 1'b0;
        st_err_q  <= 1'b0;
        irq_q     <= 1'b0;
      end
      if (abort_w) begin
        state_q <= S_IDLE;
      end else begin
        case (state_q)
          S_IDLE: if (bell_w && st_en_q) begin
            base_q    <= base_reg_q;
            cur_q     <= base_reg_q;
            fidx_q    <= '0;
            st_term_q <= 1'b0;
            state_q   <= S_FREQ;
          end
          S_FREQ: if (mem_req_ready_i) state_q <= S_FRSP;
          S_FRSP: if (mem_rsp_valid_i) begin
            case (fidx_q)
              FIDX_W'(0): cmd_q <= mem_rsp_rdata_i;
              FIDX_W'(1): src_q <= mem_rsp_rdata_i[AW-1:0];
              FIDX_W'(2): dst_q <= mem_rsp_rdata_i[AW-1:0];
              FIDX_W'(3): begin
                cntw_q <= mem_rsp_rdata_i;
                cnt_q  <= mem_rsp_rdata_i[CNT_W-1:0];
              end
              default: ;
            endcase
            if (fidx_q == FIDX_W'(DESC_WORDS - 1)) state_q <= S_CHECK;
            else begin
              fidx_q  <= fidx_q + 1'b1;
              state_q <= S_FREQ;
            end
          end
          S_CHECK: begin
            beat_q <= '0;
            if (misalign) begin
              st_err_q  <= 1'b1;
              st_halt_q <= 1'b1;
              irq_q     <= 1'b1;
              state_q   <= S_IDLE;
            end else if (cnt_q == '0) state_q <= S_ENDD;
            else state_q <= S_RREQ;
          end
          S_RREQ: if (mem_req_ready_i) state_q <= S_RRSP;
          S_RRSP: if (mem_rsp_valid_i) begin
            rbuf_q  <= mem_rsp_rdata_i;
            state_q <= S_WREQ;
          end
          S_WREQ: if (mem_req_ready_i) begin
            if (cmd_q[CMD_SINC]) src_q <= src_q + AW'(step);
            if (cmd_q[CMD_DINC]) dst_q <= dst_q + AW'(step);
            if (beat_q == beats - 6'd1) begin
              beat_q  <= '0;
              cnt_q   <= cnt_q - 1'b1;
              state_q <= (cnt_q == CNT_W'(1)) ? S_ENDD : S_RREQ;
            end else begin
              beat_q  <= beat_q + 6'd1;
              state_q <= S_RREQ;
            end
          end
          S_ENDD: begin
            if (cmd_q[CMD_LINK]) begin
              cur_q   <= next_desc;
              fidx_q  <= '0;
              state_q <= S_FREQ;
            end else begin
              st_term_q <= 1'b1;
              if (cmd_q[CMD_TIE]) irq_q <= 1'b1;
              state_q <= S_IDLE;
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end

  // R12: a pending request holds until accepted
  a_r12_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i && !abort_w |=>
      mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_we_o));

  // R9: address error always comes with halt
  a_r9_err_halts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_err_q |-> st_halt_q);

  // R7: interrupt rises only with terminate or address error
  a_r7_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (status_o[ST_TERM] || status_o[ST_ADDRERR]));

  // R11: outside a load the count only steps down by one
  a_r11_count_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o)) && !$past(cnt_load) |-> count_o == $past(count_o) - 1'b1);

  // R4: every write carries at least one strobe
  a_r4_write_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_we_o |-> mem_req_be_o != 4'b0000);
endmodule

// File: tb/test_dma_chain_engine.sv
`timescale 1ns/1ps
module test_dma_chain_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] status;
  logic [23:0] count;
  logic        irq;
  logic        req_valid, req_ready, req_we, rsp_valid;
  logic [31:0] req_addr, req_wdata, rsp_rdata;
  logic [3:0]  req_be;

  logic [31:0] mem [0:1023];
  logic [31:0] ref_mem [0:1023];
  logic        bd_we = 1'b0;
  logic [9:0]  bd_addr = '0;
  logic [31:0] bd_data = '0;
  int unsigned req_cnt = 0, wr_cnt = 0;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  dma_chain_engine i_dma_chain_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .status_o(status), .count_o(count), .irq_o(irq),
    .mem_req_valid_o(req_valid), .mem_req_ready_i(req_ready), .mem_req_we_o(req_we),
    .mem_req_addr_o(req_addr), .mem_req_wdata_o(req_wdata), .mem_req_be_o(req_be),
    .mem_rsp_valid_i(rsp_valid), .mem_rsp_rdata_i(rsp_rdata)
  );

  initial req_ready = 1'b0;
  always @(negedge clk) req_ready <= ($urandom % 4) != 0;

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (bd_we) mem[bd_addr] <= bd_data;
    else if (req_valid && req_ready) begin
      req_cnt <= req_cnt + 1;
      if (req_we) begin
        wr_cnt <= wr_cnt + 1;
        for (int i = 0; i < 4; i++)
          if (req_be[i]) mem[req_addr[11:2]][8*i +: 8] <= req_wdata[8*i +: 8];
      end else begin
        rsp_valid <= 1'b1;
        rsp_rdata <= mem[req_addr[11:2]];
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input int w, input logic [31:0] v);
    bd_we = 1'b1; bd_addr = w[9:0]; bd_data = v;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] mk_cmd(input int tsz, input bit sinc, input bit dinc,
                                         input bit link, input bit tie);
    return (32'(sinc) << 23) | (32'(dinc) << 22) | (32'(tsz) << 8) | (32'(tie) << 1) | 32'(link);
  endfunction

  task automatic put_desc(input int addr, input logic [31:0] cmd, input logic [31:0] s,
                          input logic [31:0] d, input int cnt, input int off);
    poke(addr/4,     cmd);
    poke(addr/4 + 1, s);
    poke(addr/4 + 2, d);
    poke(addr/4 + 3, {off[7:0], cnt[23:0]});
    for (int k = 4; k < 8; k++) poke(addr/4 + k, 32'hdead_0000 + k);
  endtask

  task automatic fill_data();
    for (int w = 256; w < 832; w++) begin
      logic [31:0] v;
      v = $urandom;
      poke(w, v);
      ref_mem[w] = v;
    end
  endtask

  function automatic logic [7:0] get_b(input int a);
    return ref_mem[a >> 2][8*(a & 3) +: 8];
  endfunction

  function automatic void ref_xfer(input int tsz, input bit sinc, input bit dinc,
                                   input int s, input int d, input int cnt);
    int ub, step, beats, sa, da;
    case (tsz)
      0: ub = 4; 1: ub = 1; 2: ub = 2; 3: ub = 16; 4: ub = 32; 5: ub = 64;
      default: ub = 128;
    endcase
    step  = (ub < 4) ? ub : 4;
    beats = (ub < 4) ? 1 : ub / 4;
    for (int k = 0; k < cnt; k++)
      for (int j = 0; j < beats; j++) begin
        sa = s + (sinc ? (k*beats + j)*step : 0);
        da = d + (dinc ? (k*beats + j)*step : 0);
        for (int b = 0; b < step; b++)
          ref_mem[(da + b) >> 2][8*((da + b) & 3) +: 8] = get_b(sa + b);
      end
  endfunction

  task automatic cmp_mem(input string tag);
    int mis = 0, first = -1;
    for (int w = 256; w < 832; w++)
      if (mem[w] !== ref_mem[w]) begin
        mis++;
        if (first < 0) first = w;
      end
    if (first < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, tag, mem[first], ref_mem[first]);
  endtask

  task automatic start(input int base);
    reg_wr(2'd0, base);
    reg_wr(2'd1, 32'h4000_0001);
    reg_wr(2'd2, 32'd1);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (status[3] || status[4]) break;
    end
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    quiet(2000 * 75);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int tsz_set [5] = '{0, 3, 4, 5, 6};
    int unsigned rc0;
    logic [23:0] c1, c2;
    void'($urandom(32'd4242));
    for (int w = 0; w < 1024; w++) begin mem[w] = '0; ref_mem[w] = '0; end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(status == 0 && count == 0, "R1 status/count", {8'(status[7:0]), count}, 0);
    chk(!irq && !req_valid, "R1 irq/req", {irq, req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 doorbell with enable clear is ignored
    reg_wr(2'd0, 32'h100);
    reg_wr(2'd1, 32'h0);
    rc0 = req_cnt;
    reg_wr(2'd2, 32'd1);
    quiet(30);
    chk(req_cnt == rc0, "R2 doorbell ignored", req_cnt, rc0);

    // R3/R5/R7 random word-unit copies with interrupt
    for (int it = 0; it < 6; it++) begin
      int tsz, cnt, s, d;
      tsz = tsz_set[$urandom % 5];
      cnt = 1 + $urandom % 4;
      s = 'h400 + ($urandom % 2) * 128;
      d = 'hA00 + ($urandom % 2) * 128;
      fill_data();
      put_desc('h100, mk_cmd(tsz, 1, 1, 0, 1), s, d, cnt, 0);
      ref_xfer(tsz, 1, 1, s, d, cnt);
      start('h100);
      if (it == 0) begin
        for (int i = 0; i < 50 && !req_valid; i++) @(negedge clk);
        chk(req_addr == 32'h100, "R2 first fetch at base", req_addr, 32'h100);
      end
      wait_done();
      cmp_mem("R3 word copy");
      chk(status[3] && irq, "R7 terminate+irq", status, 32'h4000_0009);
      chk(count == 0, "R11 count done", count, 0);
      reg_wr(2'd1, 32'h0);
      chk(!irq && status == 0, "R8 status clear", status, 0);
    end

    // R4 byte units, odd lanes
    fill_data();
    put_desc('h100, mk_cmd(1, 1, 1, 0, 1), 'h401, 'hA02, 5, 0);
    ref_xfer(1, 1, 1, 'h401, 'hA02, 5);
    start('h100); wait_done();
    cmp_mem("R4 byte lanes");
    reg_wr(2'd1, 0);

    // R4 halfword units
    fill_data();
    put_desc('h100, mk_cmd(2, 1, 1, 0, 1), 'h402, 'hA00, 3, 0);
    ref_xfer(2, 1, 1, 'h402, 'hA00, 3);
    start('h100); wait_done();
    cmp_mem("R4 halfword lanes");
    reg_wr(2'd1, 0);

    // R5 fixed source, then fixed target
    fill_data();
    put_desc('h100, mk_cmd(0, 0, 1, 0, 1), 'h404, 'hA00, 3, 0);
    ref_xfer(0, 0, 1, 'h404, 'hA00, 3);
    start('h100); wait_done();
    cmp_mem("R5 fixed source");
    reg_wr(2'd1, 0);
    fill_data();
    put_desc('h100, mk_cmd(3, 1, 0, 0, 1), 'h400, 'hA00, 2, 0);
    ref_xfer(3, 1, 0, 'h400, 'hA00, 2);
    start('h100); wait_done();
    cmp_mem("R5 fixed target");
    reg_wr(2'd1, 0);

    // R6 out-of-order chain: 0x100 -> 0x140 -> 0x120
    fill_data();
    put_desc('h100, mk_cmd(0, 1, 1, 1, 1), 'h400, 'hA00, 2, 4);
    put_desc('h140, mk_cmd(1, 1, 1, 1, 1), 'h410, 'hA20, 3, 2);
    put_desc('h120, mk_cmd(4, 1, 1, 0, 1), 'h480, 'hB00, 1, 0);
    ref_xfer(0, 1, 1, 'h400, 'hA00, 2);
    ref_xfer(1, 1, 1, 'h410, 'hA20, 3);
    ref_xfer(4, 1, 1, 'h480, 'hB00, 1);
    start('h100); wait_done();
    cmp_mem("R6 linked chain");
    chk(status[3] && irq, "R6 chain end irq", {status[3], irq}, 2'b11);
    reg_wr(2'd1, 0);

    // R7 end without interrupt enable
    put_desc('h100, mk_cmd(0, 1, 1, 0, 0), 'h400, 'hA00, 1, 0);
    start('h100); wait_done();
    chk(status[3] && !irq, "R7 no irq when disabled", {status[3], irq}, 2'b10);
    reg_wr(2'd1, 0);

    // R8 looping chain never ends; stop by writing 0
    fill_data();
    put_desc('h180, mk_cmd(0, 1, 1, 1, 1), 'h400, 'hA00, 2, 2);
    put_desc('h1A0, mk_cmd(0, 1, 1, 1, 1), 'h440, 'hA40, 2, 0);
    ref_xfer(0, 1, 1, 'h400, 'hA00, 2);
    ref_xfer(0, 1, 1, 'h440, 'hA40, 2);
    start('h180);
    quiet(3000);
    chk(!irq && !status[3], "R8 loop no irq", {status[3], irq}, 0);
    reg_wr(2'd1, 0);
    quiet(3);
    chk(status == 0, "R8 stop clears", status, 0);
    rc0 = req_cnt;
    quiet(40);
    chk(req_cnt == rc0, "R8 stopped no traffic", req_cnt, rc0);
    cmp_mem("R8 loop copy");

    // R9 misaligned source
    put_desc('h100, mk_cmd(3, 1, 1, 0, 1), 'h408, 'hA00, 2, 0);
    rc0 = wr_cnt;
    start('h100); wait_done();
    chk(status[4] && status[2] && irq && !status[3], "R9 address error", status, 32'h4000_0015);
    chk(wr_cnt == rc0, "R9 no writes", wr_cnt, rc0);
    reg_wr(2'd1, 0);

    // R10 zero count still follows link
    fill_data();
    put_desc('h100, mk_cmd(0, 1, 1, 1, 0), 'h400, 'hA00, 0, 2);
    put_desc('h120, mk_cmd(0, 1, 1, 0, 1), 'h420, 'hA80, 2, 0);
    ref_xfer(0, 1, 1, 'h420, 'hA80, 2);
    start('h100); wait_done();
    cmp_mem("R10 zero count link");
    chk(status[3] && irq, "R10 chain end", {status[3], irq}, 2'b11);
    reg_wr(2'd1, 0);

    // R11 live count decreases during a long transfer
    fill_data();
    put_desc('h100, mk_cmd(1, 1, 1, 0, 1), 'h400, 'hA00, 40, 0);
    ref_xfer(1, 1, 1, 'h400, 'hA00, 40);
    start('h100);
    for (int i = 0; i < 200 && count == 0; i++) @(negedge clk);
    c1 = count;
    quiet(40);
    c2 = count;
    chk(c1 != 0 && c1 <= 40 && c2 < c1 && c2 != 0, "R11 live count falls", c2, c1);
    wait_done();
    chk(count == 0, "R11 count at end", count, 0);
    cmp_mem("R12 copy under random ready");
    reg_wr(2'd1, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule